// File: doc/BRIEF.md
# Clocked Serial Receive Channel with Overrun Detection

This block receives a synchronous serial bit stream, one 8-bit frame after another, on an external serial clock. The serial clock and data pins are brought into the system clock domain through a synchroniser, and data is taken on each rising serial clock edge. Each new bit enters the shift register at the least significant end, so the first bit of a frame ends up as the most significant bit of the received byte. When the eighth bit arrives, the complete byte is copied into a receive buffer and a one-cycle completion interrupt is raised.

Software reads the buffer through a read strobe. If a frame completes while the previous byte has not been read, the byte is still overwritten, an error interrupt pulses together with the completion interrupt, and a sticky overrun flag is raised. The flag stays set until software clears it. While the buffer stays unread, every later frame raises the error again. Reception only runs while the receive enable is high. Dropping the enable discards a partial frame.

Top module: `srx_channel`

## Requirements
- R1: After reset, rd_data is 0, ovr_flag is 0 and neither interrupt output is high.
- R2: A frame is FRAME_BITS (8) bits. The first bit received lands in rd_data bit 7 and the last in bit 0. When the frame completes, rd_data takes the byte and irq_done pulses.
- R3: If a frame completes while the previous byte is unread, irq_err pulses in the same cycle as irq_done. This repeats at every further completion until the buffer is read.
- R4: On overrun, ovr_flag is set to 1 and rd_data is still replaced with the new byte.
- R5: While rx_en is 0, no frame completes and the bit count is cleared. A partial frame is discarded, and the next frame starts from its first bit once rx_en returns to 1.
- R6: ovr_flag stays 1 until ovr_clr is 1. A clear in the same cycle as an overrun keeps the flag at 0, while irq_err still pulses.
- R7: A read strobe marks the buffer as read. A read at any cycle before the completion cycle of the next frame, including between its second-to-last and last bit, prevents the overrun. A read in the completion cycle itself is too late.
- R8: irq_done and irq_err are each exactly one system clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low clears the bit count |
| sclk_in | input | 1 | Serial clock, asynchronous to clk |
| sdata_in | input | 1 | Serial data, taken on rising sclk_in |
| rd_strobe | input | 1 | One-cycle buffer read strobe |
| rd_data | output | FRAME_BITS | Receive buffer contents |
| ovr_clr | input | 1 | Clears the overrun flag; wins over a set |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_done | output | 1 | Frame completion pulse |
| irq_err | output | 1 | Overrun error pulse |

## Verification
The assertions check the following on every cycle:
- the pulse width of both interrupts;
- that an error always appears with an unread completion;
- that the flag is sticky and that a clear wins over a set;
- that the bit count clears while reception is disabled;
- that the buffer takes the assembled byte.

Only the bench scenarios can show the rest:
- the bit order across all 256 byte values, sent through the synchroniser;
- repeated errors across several unread frames;
- that a read slipped in just before the last bit still prevents overrun;
- that a partial frame cut short by the enable leaves no trace.

// File: rtl/srx_pkg.sv
package srx_pkg;
    parameter int unsigned SRX_FRAME_BITS = 8;

    typedef struct packed {
        logic done;
        logic err;
    } srx_irq_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int unsigned STAGES = 2   // must be 2 or more
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdata_in,
    output logic rise,
    output logic bit_val
);
    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic              ck_last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ck      = {st_q.ck[STAGES-2:0], sclk_in};
        st_d.dt      = {st_q.dt[STAGES-2:0], sdata_in};
        st_d.ck_last = st_q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise    = st_q.ck[STAGES-1] & ~st_q.ck_last;
    assign bit_val = st_q.dt[STAGES-1];

    // R2
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int unsigned FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_en,
    input  logic                  rise,
    input  logic                  bit_val,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] frame_word
);
    localparam int unsigned CW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CW-1:0]         cnt;
        logic [FRAME_BITS-1:0] sh;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        frame_done = 1'b0;
        frame_word = {st_q.sh[FRAME_BITS-2:0], bit_val};
        if (!rx_en) begin
            st_d = '0;
        end else if (rise) begin
            st_d.sh = frame_word;
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                frame_done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (st_q.cnt == '0));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (st_q.cnt == '0) && !frame_done);
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer
    import srx_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_done,
    input  logic [FRAME_BITS-1:0] frame_word,
    input  logic                  rd_strobe,
    input  logic                  ovr_clr,
    output logic [FRAME_BITS-1:0] rd_data,
    output logic                  ovr_flag,
    output logic                  irq_done,
    output logic                  irq_err
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] data;
        logic                  unread;
        logic                  ovr;
        srx_irq_t              irq;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;
        if (rd_strobe) st_d.unread = 1'b0;
        if (frame_done) begin
            st_d.data     = frame_word;
            st_d.unread   = 1'b1;
            st_d.irq.done = 1'b1;
            if (st_q.unread) begin
                st_d.irq.err = 1'b1;
                st_d.ovr     = 1'b1;
            end
        end
        if (ovr_clr) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign ovr_flag = st_q.ovr;
    assign irq_done = st_q.irq.done;
    assign irq_err  = st_q.irq.err;

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> irq_done && (rd_data == $past(frame_word)));

    // R3
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && st_q.unread |=> irq_err && irq_done);

    // R3
    err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> irq_done);

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && st_q.unread && !ovr_clr |=> ovr_flag);

    // R6
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr |=> !ovr_flag);

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !ovr_clr |=> ovr_flag);

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !frame_done |=> !st_q.unread);

    // R8
    done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R8
    err_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err);
endmodule

// File: rtl/srx_channel.sv
module srx_channel
    import srx_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = SRX_FRAME_BITS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_en,
    input  logic                  sclk_in,
    input  logic                  sdata_in,
    input  logic                  rd_strobe,
    output logic [FRAME_BITS-1:0] rd_data,
    input  logic                  ovr_clr,
    output logic                  ovr_flag,
    output logic                  irq_done,
    output logic                  irq_err
);
    logic                  rise;
    logic                  bit_val;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_word;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .sdata_in (sdata_in),
        .rise     (rise),
        .bit_val  (bit_val)
    );

    srx_shifter #(.FRAME_BITS(FRAME_BITS)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .rise       (rise),
        .bit_val    (bit_val),
        .frame_done (frame_done),
        .frame_word (frame_word)
    );

    srx_buffer #(.FRAME_BITS(FRAME_BITS)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .rd_strobe  (rd_strobe),
        .ovr_clr    (ovr_clr),
        .rd_data    (rd_data),
        .ovr_flag   (ovr_flag),
        .irq_done   (irq_done),
        .irq_err    (irq_err)
    );
endmodule

// File: tb/sim_srx_channel.sv
module sim_srx_channel;
    logic       clk = 1'b0;
    logic       rst_n, rx_en, sclk_in, sdata_in, rd_strobe, ovr_clr;
    logic [7:0] rd_data;
    logic       ovr_flag, irq_done, irq_err;

    int n_chk = 0, n_fail = 0;
    int done_cnt = 0, err_cnt = 0, wide_cnt = 0;
    logic done_prev = 1'b0, err_prev = 1'b0;

    always #2 clk = ~clk;

    srx_channel u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sclk_in(sclk_in),
        .sdata_in(sdata_in), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .irq_done(irq_done),
        .irq_err(irq_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_done) done_cnt++;
            if (irq_err) err_cnt++;
            if ((irq_done && done_prev) || (irq_err && err_prev)) wide_cnt++;
        end
        done_prev = irq_done;
        err_prev  = irq_err;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b;
        sclk_in  = 1'b0;
        tick(4);
        sclk_in  = 1'b1;
        tick(4);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
        tick(2);
    endtask

    task automatic read_buf();
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int d0, e0;
        rst_n = 1'b0; rx_en = 1'b0; sclk_in = 1'b0; sdata_in = 1'b0;
        rd_strobe = 1'b0; ovr_clr = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk(rd_data == 8'h00, "R1", rd_data, 0);
        chk(ovr_flag == 1'b0, "R1", ovr_flag, 0);
        chk(!irq_done && !irq_err && done_cnt == 0, "R1", done_cnt, 0);

        // R2 all byte values, read after each frame
        rx_en = 1'b1;
        tick(2);
        for (int v = 0; v < 256; v++) begin
            d0 = done_cnt;
            send_bits(8'(v), 8);
            chk(rd_data == 8'(v), "R2", rd_data, v);
            chk(done_cnt == d0 + 1, "R2", done_cnt, d0 + 1);
            read_buf();
        end
        // R7 timely reads never overrun
        chk(err_cnt == 0, "R7", err_cnt, 0);
        chk(ovr_flag == 1'b0, "R7", ovr_flag, 0);

        // R3 R4 overrun with repeat
        send_bits(8'h3C, 8);
        send_bits(8'hA5, 8);
        chk(err_cnt == 1, "R3", err_cnt, 1);
        chk(ovr_flag == 1'b1, "R4", ovr_flag, 1);
        chk(rd_data == 8'hA5, "R4", rd_data, 8'hA5);
        send_bits(8'h5A, 8);
        chk(err_cnt == 2, "R3", err_cnt, 2);
        chk(rd_data == 8'h5A, "R4", rd_data, 8'h5A);
        read_buf();
        send_bits(8'h0F, 8);
        chk(err_cnt == 2, "R7", err_cnt, 2);
        // R6 sticky, then cleared
        chk(ovr_flag == 1'b1, "R6", ovr_flag, 1);
        ovr_clr = 1'b1;
        tick(1);
        ovr_clr = 1'b0;
        chk(ovr_flag == 1'b0, "R6", ovr_flag, 0);

        // R7 read just before the last bit prevents overrun
        send_bits(8'hC3, 7);
        read_buf();
        send_bit(1'b1);
        tick(2);
        chk(err_cnt == 2, "R7", err_cnt, 2);
        chk(rd_data == 8'hC3, "R7", rd_data, 8'hC3);

        // R6 clear wins over set; error still pulses
        ovr_clr = 1'b1;
        send_bits(8'h81, 8);
        chk(err_cnt == 3, "R6", err_cnt, 3);
        chk(ovr_flag == 1'b0, "R6", ovr_flag, 0);
        ovr_clr = 1'b0;
        read_buf();

        // R5 partial frame discarded by enable drop
        send_bits(8'hFF, 4);
        rx_en = 1'b0;
        tick(2);
        rx_en = 1'b1;
        tick(2);
        d0 = done_cnt;
        send_bits(8'h66, 8);
        chk(rd_data == 8'h66, "R5", rd_data, 8'h66);
        chk(done_cnt == d0 + 1, "R5", done_cnt, d0 + 1);
        read_buf();
        rx_en = 1'b0;
        e0 = err_cnt;
        send_bits(8'h99, 8);
        chk(done_cnt == d0 + 1, "R5", done_cnt, d0 + 1);
        chk(rd_data == 8'h66, "R5", rd_data, 8'h66);
        chk(err_cnt == e0, "R5", err_cnt, e0);
        rx_en = 1'b1;

        // R8 pulse widths
        chk(wide_cnt == 0, "R8", wide_cnt, 0);
        tick(4);
        finish_run();
    end
endmodule